// File: doc/BRIEF.md
# Synchronized Push-Button Conditioner

This block turns the raw line from a mechanical push-button into two clean signals for a synchronous design. The button line carries no relation to the system clock, so it first enters a chain of flip-flops clocked by the system clock. That chain gives any undecided sample time to resolve before other logic looks at it.

After the chain, a settle timer filters out contact bounce. The reported level only moves to a new value once the synchronized signal has held that value for a set number of consecutive clock cycles. Any return to the reported value restarts the wait.

Next to the level, the block gives a one-cycle strobe on each released-to-pressed transition. Logic that counts or acts on presses therefore sees one event per physical press, however much the contacts chatter. The raw line is active high: 1 means pressed and 0 means released.

Top module: `pushbutton_conditioner`

## Requirements
- R1: The raw line reaches the filter only through SYNC_STAGES flip-flops (SYNC_STAGES of at least 2), with no logic ahead of the first one. A value sampled on the raw line becomes visible to the filter exactly SYNC_STAGES clock edges later.
- R2: While the synchronous reset is high, every synchronizer stage, the settle counter, the reported level and the press strobe clear. After a reset edge, btn_level reads 0 (released) and btn_press reads 0.
- R3: After a clean step on the raw line that is held long enough, btn_level takes the new value exactly SYNC_STAGES + SETTLE_CYCLES clock edges after the edge that first samples the new raw value.
- R4: btn_level changes only after the synchronized signal has differed from it on SETTLE_CYCLES consecutive edges. Any excursion of the raw line shorter than SETTLE_CYCLES cycles leaves btn_level and btn_press unchanged.
- R5: btn_press is high for exactly one cycle. That cycle is the first one in which btn_level reads 1 after having read 0.
- R6: A pressed-to-released transition of btn_level produces no btn_press strobe.
- R7: A press whose contacts bounce (a burst of level changes, each shorter than SETTLE_CYCLES, before a steady pressed level) yields exactly one btn_press strobe. The bounce around the following release yields none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Asynchronous button line, 1 = pressed |
| btn_level | output | 1 | Debounced button level, 1 = pressed |
| btn_press | output | 1 | One-cycle strobe on each accepted press |

## Verification
Clean steps held well past the settle interval measure the end-to-end latency, which tells the synchronizer depth and the settle count apart from an off-by-one in either. Pulses one cycle shorter than the settle interval probe the edge of the filter window and show whether the counter restarts. Pseudo-random bursts of short toggles around each press and release mimic contact chatter. They show whether a press is counted exactly once and whether a release is wrongly reported as a press.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

   typedef enum logic {
      BTN_RELEASED = 1'b0,
      BTN_PRESSED  = 1'b1
   } btn_lvl_e;

   // width of a counter that must hold values 0 .. limit-1, never less than 1
   function automatic int unsigned cnt_width(input int unsigned limit);
      int unsigned w;
      w = 1;
      while ((32'd1 << w) < limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   import pbc_pkg::*;

   logic [STAGES-1:0] stage_q;

   // first stage samples the pin directly, nothing in front of it
   always_ff @(posedge clk) begin
      if (rst) stage_q[0] <= BTN_RELEASED;
      else     stage_q[0] <= d_async;
   end

   generate
      for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage_q[gi] <= BTN_RELEASED;
            else     stage_q[gi] <= stage_q[gi-1];
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pbc_settle.sv
module pbc_settle #(
   parameter int unsigned SETTLE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_in,
   output logic level,
   output logic commit,
   output logic commit_val
);
   import pbc_pkg::*;

   localparam int unsigned CW = cnt_width(SETTLE_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

   btn_lvl_e        lvl_q;
   logic [CW-1:0]   cnt_q;
   logic            differs;

   assign differs    = (sync_in != lvl_q);
   assign commit     = differs && (cnt_q == LAST);
   assign commit_val = sync_in;
   assign level      = lvl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= BTN_RELEASED;
         cnt_q <= '0;
      end else if (!differs) begin
         cnt_q <= '0;
      end else if (commit) begin
         lvl_q <= btn_lvl_e'(sync_in);
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pbc_pulse.sv
module pbc_pulse (
   input  logic clk,
   input  logic rst,
   input  logic commit,
   input  logic commit_val,
   output logic press
);
   import pbc_pkg::*;

   logic press_q;

   always_ff @(posedge clk) begin
      if (rst) press_q <= 1'b0;
      else     press_q <= commit && (commit_val == BTN_PRESSED);
   end

   assign press = press_q;

endmodule

// File: rtl/pushbutton_conditioner.sv
module pushbutton_conditioner #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SETTLE_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic btn_level,
   output logic btn_press
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pushbutton_conditioner: SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("pushbutton_conditioner: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic sync_q;
   logic commit;
   logic commit_val;

   pbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (btn_raw),
      .q_sync  (sync_q)
   );

   pbc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk        (clk),
      .rst        (rst),
      .sync_in    (sync_q),
      .level      (btn_level),
      .commit     (commit),
      .commit_val (commit_val)
   );

   pbc_pulse u_pulse (
      .clk        (clk),
      .rst        (rst),
      .commit     (commit),
      .commit_val (commit_val),
      .press      (btn_press)
   );

endmodule

// File: rtl/pbc_checks.sv
module pbc_checks #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SETTLE_CYCLES = 4
) (
   input logic clk,
   input logic rst,
   input logic raw,
   input logic sync_q,
   input logic level,
   input logic press
);

   int unsigned age_q;   // clock edges since reset was released, saturating
   int unsigned run_q;   // consecutive edges with sync_q differing from level

   always_ff @(posedge clk) begin
      if (rst) age_q <= 0;
      else if (age_q < SYNC_STAGES + 2) age_q <= age_q + 1;
   end

   always_ff @(posedge clk) begin
      if (rst) run_q <= 0;
      else if (sync_q != level) run_q <= (run_q < SETTLE_CYCLES) ? run_q + 1 : run_q;
      else run_q <= 0;
   end

   // R1: synchronized value is the raw value from SYNC_STAGES edges earlier
   a_r1_sync_depth: assert property (@(posedge clk) disable iff (rst)
      (age_q >= SYNC_STAGES) |-> (sync_q == $past(raw, SYNC_STAGES)));

   // R2: reset clears the outputs
   a_r2_reset_clear: assert property (@(posedge clk)
      rst |=> (!level && !press));

   // R4: a level change needs SETTLE_CYCLES differing samples
   a_r4_settle_window: assert property (@(posedge clk) disable iff (rst)
      (level != $past(level)) |-> ($past(run_q) == SETTLE_CYCLES - 1));

   // R3: the new level is the value the synchronizer was presenting
   a_r3_takes_sync_value: assert property (@(posedge clk) disable iff (rst)
      (level != $past(level)) |-> (level == $past(sync_q)));

   // R5: strobe only together with a rising level
   a_r5_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
      press |-> (level && !$past(level)));

   a_r5_rise_has_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(level) |-> press);

   a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
      press |=> !press);

   // R6: falling level never strobes
   a_r6_no_release_strobe: assert property (@(posedge clk) disable iff (rst)
      $fell(level) |-> !press);

endmodule

bind pushbutton_conditioner pbc_checks #(
   .SYNC_STAGES   (SYNC_STAGES),
   .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .raw    (btn_raw),
   .sync_q (sync_q),
   .level  (btn_level),
   .press  (btn_press)
);

// File: tb/sim_pushbutton_conditioner.sv
`timescale 1ns/1ps
module sim_pushbutton_conditioner;

   localparam int S  = 3;
   localparam int ST = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn_raw = 1'b0;
   logic btn_level;
   logic btn_press;

   always #2 clk = ~clk;   // 250 MHz

   pushbutton_conditioner #(.SYNC_STAGES(S), .SETTLE_CYCLES(ST)) u0 (
      .clk       (clk),
      .rst       (rst),
      .btn_raw   (btn_raw),
      .btn_level (btn_level),
      .btn_press (btn_press)
   );

   int checks = 0;
   int errors = 0;
   string phase = "R2";

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit q_raw[$];
   int m_cnt = 0;
   bit m_lvl = 0;
   bit m_prs = 0;
   int press_seen = 0;

   always @(posedge clk) begin
      bit s;
      if (rst) begin
         q_raw = {};
         for (int i = 0; i < S; i++) q_raw.push_back(1'b0);
         m_cnt = 0; m_lvl = 0; m_prs = 0;
      end else begin
         s = q_raw.pop_front();
         q_raw.push_back(btn_raw);
         m_prs = 0;
         if (s == m_lvl) m_cnt = 0;
         else begin
            m_cnt++;
            if (m_cnt == ST) begin
               m_lvl = s; m_cnt = 0; m_prs = s;
            end
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         check({phase, " level vs model"}, btn_level, m_lvl);
         check({phase, " press vs model"}, btn_press, m_prs);
         if (btn_press) press_seen++;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<60000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   int seed = 13;
   task automatic bounce(input bit final_val, input int toggles);
      for (int i = 0; i < toggles; i++) begin
         @(negedge clk);
         btn_raw = ~btn_raw;
         seed = (seed * 1103 + 12345) % 65521;
         idle(seed % (ST - 1));
      end
      @(negedge clk);
      btn_raw = final_val;
   endtask

   initial begin
      int n0;
      // R2: reset state
      idle(3);
      check("R2 level in reset", btn_level, 0);
      check("R2 press in reset", btn_press, 0);
      @(negedge clk); rst = 1'b0;
      idle(2);
      check("R2 level after reset", btn_level, 0);

      // R1 R3: clean step latency
      phase = "R3";
      btn_raw = 1'b1;
      idle(S + ST - 1);
      check("R1 R3 level one cycle early", btn_level, 0);
      idle(1);
      check("R1 R3 level at latency", btn_level, 1);
      check("R5 press with rising level", btn_press, 1);
      idle(1);
      check("R5 press one cycle wide", btn_press, 0);
      idle(20);

      // R6: clean release
      phase = "R6";
      n0 = press_seen;
      btn_raw = 1'b0;
      idle(S + ST);
      check("R6 level released", btn_level, 0);
      check("R6 no strobe on release", btn_press, 0);
      idle(10);
      check("R6 strobe count on release", press_seen - n0, 0);

      // R4: glitches one cycle shorter than the window
      phase = "R4";
      n0 = press_seen;
      for (int k = 0; k < 4; k++) begin
         btn_raw = 1'b1; idle(ST - 1);
         btn_raw = 1'b0; idle(1);
      end
      idle(S + ST + 4);
      check("R4 level unchanged by glitches", btn_level, 0);
      check("R4 no strobe from glitches", press_seen - n0, 0);

      // R7: bounced presses, each counted once
      phase = "R7";
      for (int p = 0; p < 3; p++) begin
         n0 = press_seen;
         bounce(1'b1, 7 + p);
         idle(S + ST + 10);
         check("R7 level pressed after bounce", btn_level, 1);
         check("R7 one strobe per press", press_seen - n0, 1);
         n0 = press_seen;
         bounce(1'b0, 5 + 2 * p);
         idle(S + ST + 10);
         check("R7 level released after bounce", btn_level, 0);
         check("R7 no strobe on bounced release", press_seen - n0, 0);
      end

      // R2: reset in the middle of a held press
      phase = "R2";
      btn_raw = 1'b1;
      idle(S + ST + 4);
      @(negedge clk); rst = 1'b1;
      idle(2);
      check("R2 level cleared by reset", btn_level, 0);
      check("R2 press cleared by reset", btn_press, 0);
      @(negedge clk); rst = 1'b0;
      idle(S + ST + 4);
      check("R3 level reacquired after reset", btn_level, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule